// File: doc/BRIEF.md
# Check-Coded Memory Front-End with Sub-Word Merge

This block sits between a bus initiator and a word-wide memory that holds a check code beside every data word. Each request is a byte address, a size code and, for writes, data. A write that covers one whole word at an aligned address goes to memory at once, together with a check code computed over that word. Any narrower write makes the block fetch the stored word and repair a single flipped bit in it. It then replaces only the addressed bytes and writes the full word back with a fresh code. So the stored code always covers a complete word.

Reads always fetch a full word and check and repair it. The block then returns the requested bytes, shifted down to bit 0. Corrected faults and uncorrectable faults each set a sticky flag, and the word address of the latest faulty word is captured. The word width is a parameter, 32 or 16 bits. The memory is outside the block, on a one-cycle synchronous read/write port.

Top module: `ecc_rmw_frontend`

## Requirements
- R1: A write whose size equals the word width at an aligned address causes exactly one memory write cycle and no memory read. The response arrives 2 cycles after acceptance.
- R2: A write narrower than a word causes a memory read, then one memory write of the merged word. Only the addressed bytes change, and the response arrives 4 cycles after acceptance.
- R3: After any completed write, reading the word back returns the written data with no error response and no new error flag, so the stored check code matches the full word.
- R4: A read responds 3 cycles after acceptance. The requested bytes sit right-justified in rsp_rdata and the bits above them are zero.
- R5: A single flipped bit in a word being read, whether a data bit or a check bit, is corrected in the returned data. rsp_err stays 0, ecc_corr_flag is set and ecc_fail_addr takes the word-aligned byte address.
- R6: During a sub-word write, a single flipped bit in the stored word is corrected before the merge. The word written back is the corrected old word with the new bytes in place.
- R7: During a sub-word write, two flipped bits in the stored word abort the write. Memory is left untouched, rsp_err=1 arrives 3 cycles after acceptance, and ecc_uncorr_flag is set.
- R8: A read of a word with two flipped bits responds with rsp_err=1 and rsp_rdata=0, and sets ecc_uncorr_flag.
- R9: req_ready is 1 when idle and 0 in every cycle after an accepted memory-touching request until its response appears.
- R10: A request is rejected when its size code is 3 (8 bytes) or when offset plus length exceeds the word's byte count. It gets rsp_err=1 one cycle after acceptance, with no memory access and no change to memory.
- R11: Size code n means 2^n bytes. Byte offset o within a word maps to stored bits [8o+7:8o], with lane 0 as the least significant byte. Write data is taken from the low-order bytes of req_wdata.
- R12: All flags are 0 after reset. ecc_corr_flag and ecc_uncorr_flag stay set until reset, and ecc_fail_addr is rewritten on every detected fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Log2 of access length in bytes |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data, low-order bytes used |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DW | Read data, right-justified |
| rsp_err | output | 1 | Rejected or uncorrectable access |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW-log2(DW/8) | Word address |
| mem_wdata | output | DW | Word to store |
| mem_wchk | output | CW | Check code to store |
| mem_rdata | input | DW | Stored word, one cycle after a read |
| mem_rchk | input | CW | Stored check code, one cycle after a read |
| ecc_corr_flag | output | 1 | Sticky: a single-bit fault was corrected |
| ecc_uncorr_flag | output | 1 | Sticky: a double-bit fault was seen |
| ecc_fail_addr | output | AW | Word-aligned byte address of the latest fault |

## Verification
The hardest state to reach is a sub-word write landing on a stored word that already carries one or two flipped bits. A clean write path can never produce such a word. The bench owns the memory model and can XOR a mask into any stored data word or check code between requests. It then issues narrow writes and reads against the damaged words, and its model tracks how many bits of each word are damaged. This lets it predict the corrected merge, the aborted write that leaves the damaged word in place, and the error flags.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_STORE = 2'd3
    } seq_e;

    // Number of Hamming bits (without the overall parity bit) for a data width.
    function automatic int hamming_bits(input int dw);
        return $clog2(dw + $clog2(dw) + 1);
    endfunction

    // Code-word position of data bit k: positions that are not powers of two.
    function automatic int code_pos(input int k);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int q = 3; q < 128; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == k) pos = q;
                cnt++;
            end
        end
        return pos;
    endfunction

    // Data bits covered by Hamming check bit number bitno.
    function automatic logic [63:0] cover_mask(input int bitno, input int dw);
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < 64; k++) begin
            if (k < dw && ((code_pos(k) >> bitno) & 1) != 0) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_rmw_enc.sv
module ecc_rmw_enc
    import ecc_rmw_pkg::*;
#(
    parameter  int DW = 32,
    localparam int RB = hamming_bits(DW),
    localparam int CW = RB + 1
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    logic [RB-1:0] ham;

    for (genvar i = 0; i < RB; i++) begin : g_col
        localparam logic [63:0] COVER = cover_mask(i, DW);
        assign ham[i] = ^(data_i & COVER[DW-1:0]);
    end

    // Overall parity over data and Hamming bits gives double-error detection.
    assign chk_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec
    import ecc_rmw_pkg::*;
#(
    parameter  int DW = 32,
    localparam int RB = hamming_bits(DW),
    localparam int CW = RB + 1
) (
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] chk_i,
    output logic [DW-1:0] data_o,
    output logic          single_o,
    output logic          double_o
);

    logic [RB-1:0] syn;
    logic          par_bad;
    logic          in_range;

    for (genvar i = 0; i < RB; i++) begin : g_syn
        localparam logic [63:0] COVER = cover_mask(i, DW);
        assign syn[i] = chk_i[i] ^ (^(data_i & COVER[DW-1:0]));
    end

    assign par_bad  = ^{data_i, chk_i};
    assign in_range = (int'(syn) <= DW + RB);
    assign single_o = par_bad && in_range;
    assign double_o = (!par_bad && (syn != '0)) || (par_bad && !in_range);

    for (genvar k = 0; k < DW; k++) begin : g_fix
        localparam int P = code_pos(k);
        assign data_o[k] = data_i[k] ^ (single_o && (syn == RB'(P)));
    end

endmodule

// File: rtl/ecc_rmw_frontend.sv
module ecc_rmw_frontend
    import ecc_rmw_pkg::*;
#(
    parameter  int DW  = 32,
    parameter  int AW  = 12,
    localparam int NB  = DW / 8,
    localparam int OB  = $clog2(NB),
    localparam int WAW = AW - OB,
    localparam int RB  = hamming_bits(DW),
    localparam int CW  = RB + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [1:0]     req_size,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    output logic           rsp_err,
    output logic           mem_en,
    output logic           mem_we,
    output logic [WAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [CW-1:0]  mem_wchk,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [CW-1:0]  mem_rchk,
    output logic           ecc_corr_flag,
    output logic           ecc_uncorr_flag,
    output logic [AW-1:0]  ecc_fail_addr
);

    typedef struct packed {
        seq_e           st;
        logic           wr;
        logic [WAW-1:0] waddr;
        logic [OB-1:0]  off;
        logic [NB-1:0]  strb;
        logic [DW-1:0]  word;
        logic           rsp_v;
        logic           rsp_e;
        logic [DW-1:0]  rsp_d;
        logic           corr;
        logic           uncorr;
        logic [AW-1:0]  faddr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Request decode
    logic [3:0]    req_len;
    logic [OB-1:0] req_off;
    logic          req_bad;
    logic          req_full;
    logic [NB-1:0] req_strb;
    logic [DW-1:0] req_lanes;
    logic          req_fire;

    // Check path
    logic [DW-1:0] dec_data;
    logic          dec_single;
    logic          dec_double;
    logic [DW-1:0] lane_mask;
    logic [AW-1:0] word_byte_addr;

    ecc_rmw_enc #(.DW(DW)) u_enc (
        .data_i (ctl_q.word),
        .chk_o  (mem_wchk)
    );

    ecc_rmw_dec #(.DW(DW)) u_dec (
        .data_i   (mem_rdata),
        .chk_i    (mem_rchk),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    always_comb begin
        req_len   = 4'd1 << req_size;
        req_off   = req_addr[OB-1:0];
        req_bad   = (int'(req_len) + int'(req_off)) > NB;
        req_full  = (int'(req_len) == NB);
        req_lanes = req_wdata << {req_off, 3'b000};
        for (int b = 0; b < NB; b++) begin
            req_strb[b] = (b >= int'(req_off)) && (b < int'(req_off) + int'(req_len));
        end
        for (int b = 0; b < NB; b++) begin
            lane_mask[8*b +: 8] = {8{ctl_q.strb[b]}};
        end
    end

    assign req_fire       = req_valid && req_ready;
    assign word_byte_addr = {ctl_q.waddr, {OB{1'b0}}};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        ctl_d.rsp_e = 1'b0;
        ctl_d.rsp_d = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.wr    = req_write;
                    ctl_d.waddr = req_addr[AW-1:OB];
                    ctl_d.off   = req_off;
                    ctl_d.strb  = req_strb;
                    ctl_d.word  = req_lanes;
                    if (req_bad) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_e = 1'b1;
                    end else if (req_write && req_full) begin
                        ctl_d.st = ST_STORE;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                ctl_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (dec_double) begin
                    ctl_d.rsp_v  = 1'b1;
                    ctl_d.rsp_e  = 1'b1;
                    ctl_d.uncorr = 1'b1;
                    ctl_d.faddr  = word_byte_addr;
                    ctl_d.st     = ST_IDLE;
                end else begin
                    if (dec_single) begin
                        ctl_d.corr  = 1'b1;
                        ctl_d.faddr = word_byte_addr;
                    end
                    if (ctl_q.wr) begin
                        ctl_d.word = (dec_data & ~lane_mask) | (ctl_q.word & lane_mask);
                        ctl_d.st   = ST_STORE;
                    end else begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_d = (dec_data & lane_mask) >> {ctl_q.off, 3'b000};
                        ctl_d.st    = ST_IDLE;
                    end
                end
            end
            ST_STORE: begin
                ctl_d.rsp_v = 1'b1;
                ctl_d.st    = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready       = (ctl_q.st == ST_IDLE);
    assign mem_en          = (ctl_q.st == ST_FETCH) || (ctl_q.st == ST_STORE);
    assign mem_we          = (ctl_q.st == ST_STORE);
    assign mem_addr        = ctl_q.waddr;
    assign mem_wdata       = ctl_q.word;
    assign rsp_valid       = ctl_q.rsp_v;
    assign rsp_err         = ctl_q.rsp_e;
    assign rsp_rdata       = ctl_q.rsp_d;
    assign ecc_corr_flag   = ctl_q.corr;
    assign ecc_uncorr_flag = ctl_q.uncorr;
    assign ecc_fail_addr   = ctl_q.faddr;

    // R1: an aligned full-word write goes straight to memory in the next cycle
    p_full_write_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && req_write && req_full && !req_bad)
        |=> (mem_en && mem_we && (mem_wdata == $past(req_wdata))));

    // R2: a write not directly following acceptance was preceded by a fetch
    p_merge_fetch_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !$past(req_fire))
        |-> $past(mem_en && !mem_we, 2));

    // R7: an error response never coincides with or follows a memory write
    p_abort_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!mem_we && !$past(mem_we)));

    // R9: no request can be taken while memory is being driven
    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    // R10: a rejected request is answered without touching memory
    p_reject_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && req_bad) |=> (!mem_en && rsp_valid && rsp_err));

    // R12: fault flags are sticky
    p_corr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ecc_corr_flag) |-> ecc_corr_flag);

    p_uncorr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ecc_uncorr_flag) |-> ecc_uncorr_flag);

endmodule

// File: tb/ecc_rmw_frontend_test.sv
`timescale 1ns/1ps
module ecc_rmw_frontend_test;

    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int CW    = 7;
    localparam int WORDS = 1024;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_write = 1'b0;
    logic [1:0]     req_size = 2'd0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           rsp_valid;
    logic [DW-1:0]  rsp_rdata;
    logic           rsp_err;
    logic           mem_en;
    logic           mem_we;
    logic [9:0]     mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [CW-1:0]  mem_wchk;
    logic [DW-1:0]  rd_d;
    logic [CW-1:0]  rd_c;
    logic           ecc_corr_flag;
    logic           ecc_uncorr_flag;
    logic [AW-1:0]  ecc_fail_addr;

    always #2 clk = ~clk;

    ecc_rmw_frontend #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
        .mem_rdata(rd_d), .mem_rchk(rd_c),
        .ecc_corr_flag(ecc_corr_flag), .ecc_uncorr_flag(ecc_uncorr_flag),
        .ecc_fail_addr(ecc_fail_addr)
    );

    // Memory model with fault injection
    logic [DW-1:0] mem_d [WORDS];
    logic [CW-1:0] mem_c [WORDS];
    logic          inj_en = 1'b0;
    logic [9:0]    inj_word = '0;
    logic [DW-1:0] inj_dm = '0;
    logic [CW-1:0] inj_cm = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem_d[mem_addr] <= mem_wdata;
                mem_c[mem_addr] <= mem_wchk;
            end else begin
                rd_d <= mem_d[mem_addr];
                rd_c <= mem_c[mem_addr];
            end
        end
        if (inj_en) begin
            mem_d[inj_word] <= mem_d[inj_word] ^ inj_dm;
            mem_c[inj_word] <= mem_c[inj_word] ^ inj_cm;
        end
    end

    // Reference state
    logic [31:0]   ref_w [8];
    int            nerr [8];
    logic          exp_corr = 1'b0;
    logic          exp_unc = 1'b0;
    logic [AW-1:0] exp_fa = '0;

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic inject(input int w, input logic [DW-1:0] dm, input logic [CW-1:0] cm, input int n);
        @(negedge clk);
        inj_en = 1'b1; inj_word = 10'(w); inj_dm = dm; inj_cm = cm;
        @(negedge clk);
        inj_en = 1'b0;
        nerr[w] = n;
    endtask

    task automatic op(input logic wr, input logic [1:0] sz, input int addr,
                      input logic [31:0] wd, input string tag);
        int len, off, w, lat, cnt;
        logic bad, eerr, got, abort;
        logic [31:0] erd, raw;
        len = 1 << sz;
        off = addr % 4;
        w   = (addr / 4) % 8;
        bad = (len + off) > 4;
        eerr = 1'b0; erd = '0; lat = 0; abort = 1'b0;
        raw = mem_d[addr / 4];
        if (bad) begin
            lat = 1; eerr = 1'b1;
        end else if (wr && len == 4) begin
            lat = 2; ref_w[w] = wd; nerr[w] = 0;
        end else if (nerr[w] == 2) begin
            lat = 3; eerr = 1'b1; exp_unc = 1'b1; exp_fa = AW'(addr & ~3); abort = wr;
        end else begin
            if (nerr[w] == 1) begin exp_corr = 1'b1; exp_fa = AW'(addr & ~3); end
            if (wr) begin
                lat = 4;
                for (int b = 0; b < len; b++) ref_w[w][8*(off+b) +: 8] = wd[8*b +: 8];
                nerr[w] = 0;
            end else begin
                lat = 3;
                for (int b = 0; b < len; b++) erd[8*b +: 8] = ref_w[w][8*(off+b) +: 8];
            end
        end
        @(negedge clk);
        chk({tag, " R9 ready before request"}, req_ready, 1'b1);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = AW'(addr); req_wdata = wd;
        @(posedge clk);
        cnt = 0; got = 1'b0;
        while (!got && cnt < 12) begin
            @(negedge clk);
            req_valid = 1'b0;
            cnt++;
            if (rsp_valid) got = 1'b1;
            else chk({tag, " R9 ready low while busy"}, req_ready, 1'b0);
        end
        chk({tag, " latency"}, cnt, lat);
        chk({tag, " rsp_err"}, rsp_err, eerr);
        chk({tag, " rsp_rdata"}, rsp_rdata, erd);
        chk({tag, " R12 corr flag"}, ecc_corr_flag, exp_corr);
        chk({tag, " R12 uncorr flag"}, ecc_uncorr_flag, exp_unc);
        chk({tag, " R12 fail addr"}, ecc_fail_addr, exp_fa);
        if (bad || abort) chk({tag, " memory unchanged"}, mem_d[addr / 4], raw);
        else if (wr) chk({tag, " stored word"}, mem_d[addr / 4], ref_w[w]);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) begin ref_w[i] = '0; nerr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", req_ready, 1'b1);
        chk("R12 reset rsp_valid", rsp_valid, 1'b0);
        chk("R12 reset corr flag", ecc_corr_flag, 1'b0);
        chk("R12 reset uncorr flag", ecc_uncorr_flag, 1'b0);
        chk("R12 reset mem_en", mem_en, 1'b0);

        for (int w = 0; w < 8; w++) op(1'b1, 2'd2, 4*w, 32'h9E3779B9 * (w + 1), "R1 full write");
        for (int w = 0; w < 8; w++) op(1'b0, 2'd2, 4*w, '0, "R3 R4 full read");
        for (int b = 0; b < 4; b++) op(1'b0, 2'd0, 4 + b, '0, "R4 R11 byte read");
        op(1'b0, 2'd1, 8,  '0, "R4 R11 half read low");
        op(1'b0, 2'd1, 10, '0, "R4 R11 half read high");

        op(1'b1, 2'd0, 9,  32'hFFFFFF3C, "R2 R11 byte write");
        op(1'b0, 2'd2, 8,  '0, "R3 read after merge");
        op(1'b1, 2'd1, 14, 32'h0000BEEF, "R2 half write high");
        op(1'b1, 2'd1, 12, 32'h00001234, "R2 half write low");
        op(1'b0, 2'd2, 12, '0, "R3 read after halves");

        op(1'b1, 2'd1, 15, 32'h00005555, "R10 half crossing");
        op(1'b0, 2'd2, 6,  '0, "R10 word misaligned");
        op(1'b1, 2'd3, 0,  32'h11111111, "R10 oversize");
        op(1'b0, 2'd1, 3,  '0, "R10 half read crossing");
        op(1'b0, 2'd2, 12, '0, "R10 word intact");

        inject(4, 32'h00000020, '0, 1);
        op(1'b0, 2'd2, 16, '0, "R5 data bit fault read");
        op(1'b0, 2'd0, 17, '0, "R5 repeat byte read");
        inject(5, '0, 7'h01, 1);
        op(1'b0, 2'd1, 22, '0, "R5 check bit fault read");

        inject(6, 32'h00100000, '0, 1);
        op(1'b1, 2'd0, 24, 32'h00000077, "R6 merge over fault");
        op(1'b0, 2'd2, 24, '0, "R6 clean after merge");

        inject(7, 32'h00000208, '0, 2);
        op(1'b1, 2'd1, 28, 32'h0000AAAA, "R7 merge over double fault");
        op(1'b0, 2'd2, 28, '0, "R8 double fault read");
        op(1'b0, 2'd0, 31, '0, "R8 double fault byte read");

        op(1'b0, 2'd2, 0,  '0, "R12 flags held");
        op(1'b1, 2'd2, 28, 32'hC001D00D, "R12 rewrite faulty word");
        op(1'b0, 2'd2, 28, '0, "R3 R12 clean reread");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule